// File: doc/BRIEF.md
# Snooping Write-Invalidate Coherence Controller

This block is the coherence engine that sits beside one processor's small private write-back cache on a shared snooping bus. The cache is direct-mapped with one data word per line, and every line carries one of three coherence states: Invalid (the line counts as absent), Shared (a clean copy that other caches may also hold) or Modified (a dirty copy that no other cache holds). Processor reads and writes are served from the line array when the state allows it. Otherwise the controller requests the bus and, once granted, issues a read-miss, write-miss, invalidate or victim write-back transaction.

The controller also watches the transactions that other caches put on the bus. An invalidate or write miss for a line it holds removes its copy. A read miss for a line it holds dirty makes it drive that word on the bus in the same cycle. Memory takes that word as a write-back and drops its own fetch, and the local copy falls back to Shared. Only the bus owner can write to a shared line, so the order of bus grants fixes the order of writes to any location.

Top module: `msi_snoop_ctrl`

## Requirements
- R1: After reset every line is Invalid. `bus_req`, `cpu_ack` and `snp_flush` are low, and no snooped read miss is answered with `snp_flush`.
- R2: A processor read that misses requests the bus with command 1 (read miss) and the requested address. In the cycle after the grant edge, `cpu_ack` pulses with the word from `bus_rdata`. The line then becomes Shared even when no other cache holds it, so a repeat read is answered one cycle after acceptance with no bus request.
- R3: A processor write that hits a Shared line requests the bus with command 3 (invalidate), the line address and the write data. After the grant the line is Modified.
- R4: A processor write that hits a Modified line updates the word and acknowledges one cycle after acceptance without any bus request.
- R5: A processor write that misses requests the bus with command 2 (write miss) and the write data. After the grant the line is Modified and holds that word.
- R6: A snooped command 2 or 3 whose address matches a line held as Shared or Modified makes that line Invalid, without raising `snp_flush`.
- R7: A snooped command 1 that matches a Modified line raises `snp_flush` in the same cycle, with the line's word on `snp_data`, and the line becomes Shared.
- R8: A snooped command that matches no held line, or a read miss that matches a Shared line, leaves the line unchanged and does not raise `snp_flush`.
- R9: A miss whose index holds a Modified line of another tag first issues command 0 (write-back) with the victim's address and word, without acknowledging the processor, and then issues the miss.
- R10: A request waits with `bus_req` high and a stable command and address until `bus_gnt` is sampled high. `cpu_ack` is a single-cycle pulse.
- R11: When a snoop and an idle-state processor request fall on the same line index in one cycle, the snoop is applied first, and the request is then served against the updated state.
- R12: A snoop that arrives while a request waits for the grant is honoured. An upgrade whose Shared copy was invalidated is issued as a write miss, and a pending victim write-back whose line is no longer Modified is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cpu_req | input | 1 | Processor request, held until acknowledged |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Word address of the request |
| cpu_wdata | input | DATA_W | Write data |
| cpu_ack | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | DATA_W | Read data, valid with `cpu_ack` on reads |
| bus_req | output | 1 | Request for bus ownership |
| bus_gnt | input | 1 | Grant; the transaction completes at the edge where it is high |
| bus_cmd | output | 2 | 0 write-back, 1 read miss, 2 write miss, 3 invalidate |
| bus_addr | output | ADDR_W | Transaction address |
| bus_wdata | output | DATA_W | Write-back or write data |
| bus_rdata | input | DATA_W | Fill data for a granted read miss |
| snp_valid | input | 1 | Another cache's transaction is on the bus |
| snp_cmd | input | 2 | Snooped command, same encoding as `bus_cmd` |
| snp_addr | input | ADDR_W | Snooped address |
| snp_flush | output | 1 | This cache supplies the word and memory aborts its fetch |
| snp_data | output | DATA_W | Supplied dirty word |

## Verification
The hardest case to reach from the ports is a snoop that changes a line while the controller is already waiting for the grant on that same line. The upgrade must turn into a write miss, and a dirty victim that was just flushed must not be written back a second time. The bench reaches this by holding the grant back for a chosen number of cycles and injecting a snoop on the second waiting cycle. A reference model of the states, tags and memory predicts the exact transaction list, and a long pseudo-random sweep over all sixteen addresses mixes local operations with both same-cycle and late snoops.

// File: rtl/msi_pkg.sv
package msi_pkg;
  typedef enum logic [1:0] {
    LN_INV = 2'd0,
    LN_SHR = 2'd1,
    LN_MOD = 2'd2
  } line_st_e;

  typedef enum logic [1:0] {
    BUS_WB     = 2'd0,
    BUS_RDMISS = 2'd1,
    BUS_WRMISS = 2'd2,
    BUS_INVAL  = 2'd3
  } bus_cmd_e;

  typedef enum logic {
    CTL_IDLE = 1'b0,
    CTL_PEND = 1'b1
  } ctl_st_e;
endpackage

// File: rtl/msi_line_store.sv
module msi_line_store
  import msi_pkg::*;
#(
  parameter int IDX_W  = 2,
  parameter int TAG_W  = 2,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  rd_idx,
  output line_st_e          rd_st,
  output logic [TAG_W-1:0]  rd_tag,
  output logic [DATA_W-1:0] rd_data,
  input  logic [IDX_W-1:0]  sn_idx,
  output line_st_e          sn_st,
  output logic [TAG_W-1:0]  sn_tag,
  output logic [DATA_W-1:0] sn_data,
  input  logic              wr_en,
  input  line_st_e          wr_st,
  input  logic [TAG_W-1:0]  wr_tag,
  input  logic              wr_dwe,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              sn_we,
  input  line_st_e          sn_new
);
  localparam int LINES = 1 << IDX_W;

  line_st_e          st_q  [LINES];
  logic [TAG_W-1:0]  tag_q [LINES];
  logic [DATA_W-1:0] dat_q [LINES];

  assign rd_st   = st_q[rd_idx];
  assign rd_tag  = tag_q[rd_idx];
  assign rd_data = dat_q[rd_idx];
  assign sn_st   = st_q[sn_idx];
  assign sn_tag  = tag_q[sn_idx];
  assign sn_data = dat_q[sn_idx];

  // Local writes use rd_idx; a snoop update to the same line wins.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < LINES; i++) begin
        st_q[i]  <= LN_INV;
        tag_q[i] <= '0;
        dat_q[i] <= '0;
      end
    end else begin
      for (int i = 0; i < LINES; i++) begin
        if (wr_en && rd_idx == i[IDX_W-1:0]) begin
          st_q[i]  <= wr_st;
          tag_q[i] <= wr_tag;
          if (wr_dwe) dat_q[i] <= wr_data;
        end
        if (sn_we && sn_idx == i[IDX_W-1:0]) st_q[i] <= sn_new;
      end
    end
  end
endmodule

// File: rtl/msi_snoop_eval.sv
module msi_snoop_eval
  import msi_pkg::*;
#(
  parameter int TAG_W = 2
) (
  input  logic             snp_valid,
  input  logic [1:0]       snp_cmd,
  input  logic [TAG_W-1:0] snp_tag,
  input  line_st_e         ln_st,
  input  logic [TAG_W-1:0] ln_tag,
  output logic             flush,
  output logic             upd,
  output line_st_e         new_st
);
  logic held;
  assign held = snp_valid && (ln_st != LN_INV) && (ln_tag == snp_tag);

  always_comb begin
    flush  = 1'b0;
    upd    = 1'b0;
    new_st = ln_st;
    case (bus_cmd_e'(snp_cmd))
      BUS_RDMISS: begin
        flush  = held && (ln_st == LN_MOD);
        upd    = flush;
        new_st = LN_SHR;
      end
      BUS_WRMISS, BUS_INVAL: begin
        upd    = held;
        new_st = LN_INV;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/msi_snoop_ctrl.sv
module msi_snoop_ctrl
  import msi_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int IDX_W  = 2,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic              cpu_ack,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              bus_req,
  input  logic              bus_gnt,
  output logic [1:0]        bus_cmd,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic [DATA_W-1:0] bus_rdata,
  input  logic              snp_valid,
  input  logic [1:0]        snp_cmd,
  input  logic [ADDR_W-1:0] snp_addr,
  output logic              snp_flush,
  output logic [DATA_W-1:0] snp_data
);
  localparam int TAG_W = ADDR_W - IDX_W;

  function automatic logic [IDX_W-1:0] addr_idx(input logic [ADDR_W-1:0] a);
    return a[IDX_W-1:0];
  endfunction
  function automatic logic [TAG_W-1:0] addr_tag(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1:IDX_W];
  endfunction
  function automatic logic [ADDR_W-1:0] join_addr(input logic [TAG_W-1:0] t,
                                                  input logic [IDX_W-1:0] i);
    return {t, i};
  endfunction

  ctl_st_e           ctl_q;
  logic [ADDR_W-1:0] pend_addr_q;
  logic              pend_we_q, pend_wb_q, cpu_ack_q;
  logic [DATA_W-1:0] pend_wd_q, cpu_rdata_q;

  logic [ADDR_W-1:0] cur_addr;
  line_st_e          lk_st, sn_st, sn_new, wr_st;
  logic [TAG_W-1:0]  lk_tag, sn_tag, wr_tag;
  logic [DATA_W-1:0] lk_data, sn_data, wr_data;
  logic              lk_hit, sn_upd, sn_flush, wr_en, wr_dwe;
  bus_cmd_e          cmd_w;

  // Named events for the checker
  logic ctl_idle, snp_clash, accept, ev_rd_hit, ev_local_write, ev_go_bus;
  logic victim_dirty, wb_alive, ev_wb_drop, ev_bus_done;

  assign ctl_idle = (ctl_q == CTL_IDLE);
  assign cur_addr = ctl_idle ? cpu_addr : pend_addr_q;
  assign lk_hit   = (lk_st != LN_INV) && (lk_tag == addr_tag(cur_addr));

  msi_line_store #(.IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_store (
    .clk(clk), .rst_n(rst_n),
    .rd_idx(addr_idx(cur_addr)), .rd_st(lk_st), .rd_tag(lk_tag), .rd_data(lk_data),
    .sn_idx(addr_idx(snp_addr)), .sn_st(sn_st), .sn_tag(sn_tag), .sn_data(sn_data),
    .wr_en(wr_en), .wr_st(wr_st), .wr_tag(wr_tag), .wr_dwe(wr_dwe), .wr_data(wr_data),
    .sn_we(sn_upd), .sn_new(sn_new)
  );

  msi_snoop_eval #(.TAG_W(TAG_W)) u_snoop (
    .snp_valid(snp_valid), .snp_cmd(snp_cmd), .snp_tag(addr_tag(snp_addr)),
    .ln_st(sn_st), .ln_tag(sn_tag),
    .flush(sn_flush), .upd(sn_upd), .new_st(sn_new)
  );

  assign snp_flush = sn_flush;
  assign snp_data  = sn_data;

  // Snoop to the same index as an idle request is served first.
  assign snp_clash      = snp_valid && (addr_idx(snp_addr) == addr_idx(cur_addr));
  assign accept         = ctl_idle && cpu_req && !cpu_ack_q && !snp_clash;
  assign ev_rd_hit      = accept && !cpu_we && lk_hit;
  assign ev_local_write = accept && cpu_we && lk_hit && (lk_st == LN_MOD);
  assign ev_go_bus      = accept && !ev_rd_hit && !ev_local_write;
  assign victim_dirty   = !lk_hit && (lk_st == LN_MOD);

  assign wb_alive    = pend_wb_q && (lk_st == LN_MOD);
  assign ev_wb_drop  = !ctl_idle && pend_wb_q && !wb_alive;
  assign bus_req     = !ctl_idle && (!pend_wb_q || wb_alive);
  assign ev_bus_done = bus_req && bus_gnt;

  always_comb begin
    if (pend_wb_q)      cmd_w = BUS_WB;
    else if (!pend_we_q) cmd_w = BUS_RDMISS;
    else if (lk_hit)    cmd_w = BUS_INVAL;
    else                cmd_w = BUS_WRMISS;
  end
  assign bus_cmd   = cmd_w;
  assign bus_addr  = pend_wb_q ? join_addr(lk_tag, addr_idx(pend_addr_q)) : pend_addr_q;
  assign bus_wdata = pend_wb_q ? lk_data : pend_wd_q;

  // Line array update from the local side
  assign wr_en  = ev_local_write || ev_bus_done;
  assign wr_dwe = ev_local_write || (ev_bus_done && !pend_wb_q);
  assign wr_tag = (ev_bus_done && pend_wb_q) ? lk_tag : addr_tag(cur_addr);
  always_comb begin
    if (ev_local_write)      wr_st = LN_MOD;
    else if (pend_wb_q)      wr_st = LN_INV;
    else if (!pend_we_q)     wr_st = LN_SHR;
    else                     wr_st = LN_MOD;
  end
  assign wr_data = ev_local_write ? cpu_wdata : (pend_we_q ? pend_wd_q : bus_rdata);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q       <= CTL_IDLE;
      pend_addr_q <= '0;
      pend_we_q   <= 1'b0;
      pend_wd_q   <= '0;
      pend_wb_q   <= 1'b0;
      cpu_ack_q   <= 1'b0;
      cpu_rdata_q <= '0;
    end else begin
      cpu_ack_q <= 1'b0;
      if (ctl_idle) begin
        if (ev_rd_hit) begin
          cpu_ack_q   <= 1'b1;
          cpu_rdata_q <= lk_data;
        end
        if (ev_local_write) cpu_ack_q <= 1'b1;
        if (ev_go_bus) begin
          ctl_q       <= CTL_PEND;
          pend_addr_q <= cpu_addr;
          pend_we_q   <= cpu_we;
          pend_wd_q   <= cpu_wdata;
          pend_wb_q   <= victim_dirty;
        end
      end else if (ev_wb_drop) begin
        ctl_q     <= CTL_IDLE;
        pend_wb_q <= 1'b0;
      end else if (ev_bus_done) begin
        ctl_q     <= CTL_IDLE;
        pend_wb_q <= 1'b0;
        if (!pend_wb_q) begin
          cpu_ack_q <= 1'b1;
          if (!pend_we_q) cpu_rdata_q <= bus_rdata;
        end
      end
    end
  end

  assign cpu_ack   = cpu_ack_q;
  assign cpu_rdata = cpu_rdata_q;
endmodule

// File: rtl/msi_snoop_ctrl_chk.sv
module msi_snoop_ctrl_chk #(
  parameter int ADDR_W = 4,
  parameter int IDX_W  = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cpu_req,
  input logic [ADDR_W-1:0] cpu_addr,
  input logic              cpu_ack,
  input logic              bus_req,
  input logic              bus_gnt,
  input logic [1:0]        bus_cmd,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              snp_valid,
  input logic [1:0]        snp_cmd,
  input logic [ADDR_W-1:0] snp_addr,
  input logic              snp_flush,
  input logic              ctl_idle,
  input logic              ev_local_write
);
  // R10
  ack_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ack |=> !cpu_ack);

  // R10
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && !bus_gnt && !snp_valid |=> bus_req && $stable(bus_cmd) && $stable(bus_addr));

  // R7
  flush_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    snp_flush |-> snp_valid && snp_cmd == 2'd1);

  // R4
  silent_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_local_write |=> cpu_ack && !bus_req);

  // R2
  done_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && bus_gnt && bus_cmd != 2'd0 |=> cpu_ack);

  // R9
  wb_no_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && bus_gnt && bus_cmd == 2'd0 |=> !cpu_ack);

  // R11
  clash_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_idle && cpu_req && !cpu_ack && snp_valid &&
    snp_addr[IDX_W-1:0] == cpu_addr[IDX_W-1:0] |=> !cpu_ack && !bus_req);

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_n |-> !bus_req && !cpu_ack);
endmodule

bind msi_snoop_ctrl msi_snoop_ctrl_chk #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_addr(cpu_addr),
  .cpu_ack(cpu_ack), .bus_req(bus_req), .bus_gnt(bus_gnt), .bus_cmd(bus_cmd),
  .bus_addr(bus_addr), .snp_valid(snp_valid), .snp_cmd(snp_cmd),
  .snp_addr(snp_addr), .snp_flush(snp_flush), .ctl_idle(ctl_idle),
  .ev_local_write(ev_local_write)
);

// File: tb/msi_snoop_ctrl_tb.sv
`timescale 1ns/1ps
module msi_snoop_ctrl_tb;
  localparam int AW = 4, IW = 2, DW = 8;
  localparam int NL = 4, NA = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic          cpu_req = 0, cpu_we = 0, cpu_ack;
  logic [AW-1:0] cpu_addr = 0;
  logic [DW-1:0] cpu_wdata = 0, cpu_rdata;
  logic          bus_req, bus_gnt = 0;
  logic [1:0]    bus_cmd;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] bus_wdata, bus_rdata;
  logic          snp_valid = 0, snp_flush;
  logic [1:0]    snp_cmd = 0;
  logic [AW-1:0] snp_addr = 0;
  logic [DW-1:0] snp_data;

  logic [DW-1:0] mem [NA];
  assign bus_rdata = mem[bus_addr];

  msi_snoop_ctrl #(.ADDR_W(AW), .IDX_W(IW), .DATA_W(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_ack(cpu_ack),
    .cpu_rdata(cpu_rdata), .bus_req(bus_req), .bus_gnt(bus_gnt),
    .bus_cmd(bus_cmd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .snp_valid(snp_valid), .snp_cmd(snp_cmd),
    .snp_addr(snp_addr), .snp_flush(snp_flush), .snp_data(snp_data)
  );

  int n_chk = 0, n_fail = 0;
  bit finished = 0;
  // reference model: 0 invalid, 1 shared, 2 modified
  int m_st [NL];
  int m_tg [NL];
  int m_dt [NL];

  task automatic chk(input bit ok, input string lbl, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", lbl, act, exp);
    end
  endtask

  task automatic snp_model(input int c, input int a, output bit f, output int fd, output string lbl);
    int i = a % NL, t = a / NL;
    bit held = (m_st[i] != 0) && (m_tg[i] == t);
    f = held && m_st[i] == 2 && c == 1;
    fd = m_dt[i];
    lbl = f ? "R7 snoop flush" : ((held && c >= 2) ? "R6 snoop invalidate" : "R8 snoop no effect");
    if (f) m_st[i] = 1;
    if (held && c >= 2) m_st[i] = 0;
  endtask

  task automatic do_snoop(input int c, input int a);
    bit f; int fd; string l;
    snp_model(c, a, f, fd, l);
    @(posedge clk); #1;
    snp_valid = 1; snp_cmd = 2'(c); snp_addr = AW'(a);
    @(negedge clk);
    chk(snp_flush == f, l, snp_flush, f);
    if (f) begin
      chk(snp_data == DW'(fd), {l, " data"}, snp_data, fd);
      mem[a] = snp_data;
    end
    @(posedge clk); #1;
    snp_valid = 0;
  endtask

  task automatic do_cpu(input bit we, input int a, input int wd, input int gd,
                        input bit sv, input int sc, input int sa,
                        input bit ls_in, input int lsc, input int lsa);
    bit ef, lf, hit, done, ls, ls_done;
    int efd, lfd, i, t, e_n, k, cnt, f_cmd, f_adr, cap_a, cap_d;
    int e_cmd [2]; int e_adr [2]; int e_dat [2];
    string sl, ll, lbl;
    ls = ls_in; ls_done = 0; e_n = 0; ef = 0; lf = 0; efd = 0; lfd = 0;
    f_cmd = 0; f_adr = 0;
    if (sv) snp_model(sc, sa, ef, efd, sl);
    i = a % NL; t = a / NL;
    hit = (m_st[i] != 0) && (m_tg[i] == t);
    if ((!we && hit) || (we && hit && m_st[i] == 2) || gd < 2) ls = 0;
    if (ls) begin
      snp_model(lsc, lsa, lf, lfd, ll);
      hit = (m_st[i] != 0) && (m_tg[i] == t);
    end
    lbl = "";
    if (!hit && m_st[i] == 2) begin
      e_cmd[0] = 0; e_adr[0] = m_tg[i] * NL + i; e_dat[0] = m_dt[i]; e_n = 1;
      lbl = "R9 victim ";
    end
    if (!we) begin
      if (hit) lbl = {lbl, "R2 read hit"};
      else begin
        e_cmd[e_n] = 1; e_adr[e_n] = a; e_dat[e_n] = -1; e_n++;
        lbl = {lbl, "R2 read miss"};
      end
    end else begin
      if (hit && m_st[i] == 2) lbl = {lbl, "R4 write modified"};
      else if (hit) begin
        e_cmd[e_n] = 3; e_adr[e_n] = a; e_dat[e_n] = wd; e_n++;
        lbl = {lbl, "R3 write shared"};
      end else begin
        e_cmd[e_n] = 2; e_adr[e_n] = a; e_dat[e_n] = wd; e_n++;
        lbl = {lbl, "R5 write miss"};
      end
    end
    if (sv) lbl = {lbl, " R11"};
    if (ls) lbl = {lbl, " R12"};
    if (gd > 2) lbl = {lbl, " R10"};

    @(posedge clk); #1;
    cpu_req = 1; cpu_we = we; cpu_addr = AW'(a); cpu_wdata = DW'(wd);
    if (sv) begin snp_valid = 1; snp_cmd = 2'(sc); snp_addr = AW'(sa); end
    @(negedge clk);
    if (sv) begin
      chk(snp_flush == ef, {sl, " R11"}, snp_flush, ef);
      if (ef) begin
        chk(snp_data == DW'(efd), {sl, " data"}, snp_data, efd);
        mem[sa] = snp_data;
      end
    end
    @(posedge clk); #1;
    snp_valid = 0;
    done = 0; k = 0; cnt = 0;
    for (int cyc = 0; cyc < 80 && !done; cyc++) begin
      @(negedge clk);
      if (cpu_ack) done = 1;
      else if (bus_req) begin
        if (cnt == 0) begin f_cmd = bus_cmd; f_adr = bus_addr; end
        if (cnt == gd) begin
          if (k < e_n) begin
            chk(bus_cmd == 2'(e_cmd[k]), {lbl, " cmd"}, bus_cmd, e_cmd[k]);
            chk(bus_addr == AW'(e_adr[k]), {lbl, " addr"}, bus_addr, e_adr[k]);
            if (e_dat[k] >= 0)
              chk(bus_wdata == DW'(e_dat[k]), {lbl, " data"}, bus_wdata, e_dat[k]);
            if (!ls && gd > 0)
              chk(f_cmd == int'(bus_cmd) && f_adr == int'(bus_addr),
                  "R10 held request stable", f_adr, bus_addr);
          end else chk(0, {lbl, " extra bus transaction"}, bus_cmd, -1);
          cap_a = bus_addr; cap_d = bus_wdata;
          bus_gnt = 1;
          @(posedge clk);
          if (k < e_n && e_cmd[k] == 0) mem[cap_a] = DW'(cap_d);
          #1; bus_gnt = 0;
          k++; cnt = 0;
        end else begin
          if (ls && !ls_done && cnt == 1) begin
            ls_done = 1;
            snp_valid = 1; snp_cmd = 2'(lsc); snp_addr = AW'(lsa);
            #1;
            chk(snp_flush == lf, {ll, " R12 late"}, snp_flush, lf);
            if (lf) mem[lsa] = snp_data;
            @(posedge clk); #1;
            snp_valid = 0;
          end
          cnt++;
        end
      end
    end
    chk(done, {lbl, " ack"}, done, 1);
    chk(k == e_n, {lbl, " transaction count"}, k, e_n);
    if (!we) begin
      int expv = hit ? m_dt[i] : int'(mem[a]);
      chk(cpu_rdata == DW'(expv), {lbl, " rdata"}, cpu_rdata, expv);
      if (!hit) m_dt[i] = mem[a];
      m_st[i] = hit ? m_st[i] : 1;
    end else begin
      m_st[i] = 2; m_dt[i] = wd;
    end
    m_tg[i] = t;
    @(posedge clk); #1;
    cpu_req = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    for (int a = 0; a < NA; a++) mem[a] = DW'(a * 7 + 3);
    for (int i = 0; i < NL; i++) begin m_st[i] = 0; m_tg[i] = 0; m_dt[i] = 0; end
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    chk(!bus_req, "R1 reset bus_req", bus_req, 0);
    chk(!cpu_ack, "R1 reset cpu_ack", cpu_ack, 0);
    chk(!snp_flush, "R1 reset snp_flush", snp_flush, 0);
    for (int a = 0; a < NA; a++) do_snoop(1, a);  // R1: nothing held

    // R2 / R3 / R4 sequence on one line
    do_cpu(0, 1, 0, 0, 0, 0, 0, 0, 0, 0);
    do_cpu(0, 1, 0, 1, 0, 0, 0, 0, 0, 0);
    do_cpu(1, 1, 8'h5a, 1, 0, 0, 0, 0, 0, 0);
    do_cpu(1, 1, 8'h66, 0, 0, 0, 0, 0, 0, 0);
    do_cpu(0, 1, 0, 0, 0, 0, 0, 0, 0, 0);
    // R5 then R7 downgrade, then R3 upgrade shows Shared
    do_cpu(1, 2, 8'h21, 0, 0, 0, 0, 0, 0, 0);
    do_snoop(1, 2);
    do_snoop(1, 2);                                // R8 on Shared line
    do_cpu(1, 2, 8'h22, 0, 0, 0, 0, 0, 0, 0);
    // R6 invalidations, then misses again
    do_snoop(2, 1);
    do_cpu(0, 1, 0, 0, 0, 0, 0, 0, 0, 0);
    do_snoop(3, 1);
    do_cpu(1, 1, 8'h31, 0, 0, 0, 0, 0, 0, 0);
    do_snoop(2, 9);                                // R8: other tag
    // R9 conflict with dirty victim
    do_cpu(1, 3, 8'h44, 0, 0, 0, 0, 0, 0, 0);
    do_cpu(0, 7, 0, 2, 0, 0, 0, 0, 0, 0);
    do_cpu(0, 3, 0, 0, 0, 0, 0, 0, 0, 0);
    // R10 long grant wait
    do_cpu(1, 11, 8'h77, 6, 0, 0, 0, 0, 0, 0);
    // R11 same-cycle snoop on same index
    do_cpu(0, 11, 0, 0, 1, 2, 11, 0, 0, 0);
    do_cpu(1, 6, 8'h12, 0, 0, 0, 0, 0, 0, 0);
    do_cpu(0, 6, 0, 0, 1, 1, 6, 0, 0, 0);
    // R12 late snoops while waiting for grant
    do_cpu(0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    do_cpu(1, 0, 8'h91, 4, 0, 0, 0, 1, 3, 0);
    do_cpu(0, 4, 0, 4, 0, 0, 0, 1, 1, 0);

    // near-exhaustive pseudo-random sweep
    seed = 32'h1234_5678;
    for (int n = 0; n < 600; n++) begin
      int unsigned r0, r1;
      seed = seed * 1103515245 + 12345; r0 = seed;
      seed = seed * 1103515245 + 12345; r1 = seed;
      do_cpu(r0[0], int'(r0[7:4]), int'(r0[15:8]), int'(r0[17:16]),
             r0[18], int'(r0[20:19] == 0 ? 2'd1 : r0[20:19]), int'(r0[24:21] & 4'hf),
             r1[3:2] == 0, int'(r1[5:4] == 0 ? 2'd2 : r1[5:4]), int'(r1[11:8]));
      if (r1[15:13] == 0) do_snoop(int'(r1[17:16] == 0 ? 2'd1 : r1[17:16]), int'(r1[23:20]));
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule